// File: doc/BRIEF.md
# Cascadable Strobe-Framed Serial Control Port

This block is a slave serial port. In one transfer it takes an 8-bit output-control word from a host and returns an 8-bit diagnostic word. The host drives a serial clock, a data line and a select strobe. The port answers on a serial data output and raises a select output that passes the shared clock on to the next port in a chain. Any number of ports can therefore share one clock and one data line. Each port takes the nine clock periods that follow the moment its own select input rises.

On the core side, the port presents the received word as a parallel control word, together with a one-cycle update pulse. Bit i of that word selects the high-side driver (1) or the low-side driver (0) of output i+1. The port samples a parallel diagnostic word in which bit i, when high, flags that output i+1 was shut down for overload.

The serial pins are not used as clocks. Two-flop synchronizers bring all three of them into the system clock domain, and their edges are detected there. The system clock must run at least 8 times faster than the serial clock. Every port output settles within four system clock cycles of the pin edge that causes it.

Top module: `chain_ctl_port`

## Requirements
- R1: After reset, ctrl_o is 0, ctrl_upd_o is 0, sdout_o is 0 and sel_o is 0.
- R2: A rise of sel_i captures diag_i and sets sdout_o to 0. Serial-clock rising edge k (k = 1..8) then drives diag bit 8-k onto sdout_o, so bit 7 comes out first and bit 0 last. sdout_o then keeps its value until the frame ends.
- R3: Serial-clock falling edge k (k = 1..8) takes sdin_i in as control bit 8-k, so the first bit is bit 7 and the eighth is bit 0.
- R4: The ninth rising edge of a frame copies the received word onto ctrl_o and raises ctrl_upd_o for exactly one system clock cycle. ctrl_o changes at no other time.
- R5: The ninth falling edge of a frame raises sel_o. After that, serial-clock edges change neither sdout_o nor ctrl_o, and they raise no update pulse, until sel_i goes low and then high again.
- R6: When sel_i goes low, sel_o goes low. A frame that ends with fewer than nine rising edges leaves ctrl_o unchanged and raises no update pulse.
- R7: sdout_o is 0 while sel_i is low, and serial-clock edges seen while sel_i is low have no effect.
- R8: When two ports are chained (sel_o of the first drives sel_i of the second), the second port takes clock periods 10 to 17 of one select window as its bits 7 to 0, and returns its own diagnostic word on its sdout_o over those same periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial control data in |
| sel_i | input | 1 | Select strobe in, high frames a transfer |
| sdout_o | output | 1 | Serial diagnostic data out |
| sel_o | output | 1 | Select strobe out to the next port |
| ctrl_o | output | 8 | Committed control word |
| ctrl_upd_o | output | 1 | One-cycle pulse when ctrl_o is loaded |
| diag_i | input | 8 | Diagnostic word sampled at the select rise |

## Verification
A wrong bit counter shows up on the ports as early as the first wrong edge. Either sdout_o carries a diagnostic bit from the wrong position within four system cycles of that rising edge, or ctrl_o commits a shifted word at the ninth rise. If the freeze state is lost, the extra edges after the hand-off alter sdout_o or raise a second update pulse. If the select logic is wrong, sel_o stays high after sel_i falls, or the chained port receives the wrong word. The reference model in the bench tracks edge counts and expected outputs, and it compares them on every settled system clock cycle.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
  // Synchronized view of one serial pin.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/ccp_sync.sv
`timescale 1ns/1ps
module ccp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/ccp_edge.sv
`timescale 1ns/1ps
module ccp_edge #(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin,
  output ccp_pkg::edge_t  ev
);
  logic lvl;
  logic prev_q, prev_n;

  ccp_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(lvl)
  );

  always_comb prev_n = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_n;
  end

  assign ev.level = lvl;
  assign ev.rise  = lvl & ~prev_q;
  assign ev.fall  = ~lvl & prev_q;
endmodule

// File: rtl/ccp_frame_seq.sv
`timescale 1ns/1ps
module ccp_frame_seq #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_lvl,
  input  logic sel_rise,
  input  logic sel_fall,
  input  logic sck_rise,
  input  logic sck_fall,
  output logic load,
  output logic shift_in,
  output logic shift_out,
  output logic commit,
  output logic sel_o
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic          open_q, open_n;
  logic [CW-1:0] rcnt_q, rcnt_n;
  logic [CW-1:0] fcnt_q, fcnt_n;
  logic          selo_q, selo_n;

  // Edge decode for the datapath
  assign load      = sel_rise;
  assign shift_out = open_q & ~sel_rise & sel_lvl & sck_rise & (rcnt_q < LAST);
  assign commit    = open_q & ~sel_rise & sel_lvl & sck_rise & (rcnt_q == LAST) & (fcnt_q == LAST);
  assign shift_in  = open_q & ~sel_rise & sel_lvl & sck_fall & (fcnt_q < LAST);

  always_comb begin
    open_n = open_q;
    rcnt_n = rcnt_q;
    fcnt_n = fcnt_q;
    selo_n = selo_q;
    if (!sel_lvl || sel_fall) begin
      open_n = 1'b0;
      rcnt_n = '0;
      fcnt_n = '0;
      selo_n = 1'b0;
    end else if (sel_rise) begin
      open_n = 1'b1;
      rcnt_n = '0;
      fcnt_n = '0;
      selo_n = 1'b0;
    end else if (open_q) begin
      if (sck_rise && rcnt_q <= LAST) rcnt_n = rcnt_q + 1'b1;
      if (sck_fall) begin
        if (fcnt_q < LAST) begin
          fcnt_n = fcnt_q + 1'b1;
        end else begin
          fcnt_n = fcnt_q + 1'b1;
          selo_n = 1'b1;
          open_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcnt_q <= '0;
      fcnt_q <= '0;
      selo_q <= 1'b0;
    end else begin
      open_q <= open_n;
      rcnt_q <= rcnt_n;
      fcnt_q <= fcnt_n;
      selo_q <= selo_n;
    end
  end

  assign sel_o = selo_q;

  AST_HANDOFF_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selo_q) |-> (rcnt_q == LAST + 1'b1)) else $error("handoff before ninth rise"); // R5
  AST_SELO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_lvl |=> !selo_q) else $error("sel_o held without sel_i"); // R6
  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (selo_q && sel_lvl) |-> (!shift_in && !shift_out && !commit)) else $error("activity while frozen"); // R5
endmodule

// File: rtl/ccp_shifter.sv
`timescale 1ns/1ps
module ccp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift_in,
  input  logic         shift_out,
  input  logic         commit,
  input  logic         din,
  input  logic         sel_lvl,
  input  logic [W-1:0] diag,
  output logic [W-1:0] ctrl,
  output logic         upd,
  output logic         sdout
);
  logic [W-1:0] rx_q, rx_n;
  logic [W-1:0] tx_q, tx_n;
  logic [W-1:0] ctrl_q, ctrl_n;
  logic         obit_q, obit_n;
  logic         upd_q, upd_n;

  always_comb begin
    rx_n   = rx_q;
    tx_n   = tx_q;
    obit_n = obit_q;
    ctrl_n = ctrl_q;
    upd_n  = 1'b0;
    if (load) begin
      rx_n   = '0;
      tx_n   = diag;
      obit_n = 1'b0;
    end else begin
      if (shift_in)  rx_n = {rx_q[W-2:0], din};
      if (shift_out) begin
        obit_n = tx_q[W-1];
        tx_n   = {tx_q[W-2:0], 1'b0};
      end
      if (commit) begin
        ctrl_n = rx_q;
        upd_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      obit_q <= 1'b0;
      ctrl_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      obit_q <= obit_n;
      ctrl_q <= ctrl_n;
      upd_q  <= upd_n;
    end
  end

  assign ctrl  = ctrl_q;
  assign upd   = upd_q;
  assign sdout = sel_lvl & obit_q;

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q) else $error("update pulse too long"); // R4
  AST_CTRL_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> upd_q) else $error("ctrl changed without update"); // R4
endmodule

// File: rtl/chain_ctl_port.sv
`timescale 1ns/1ps
module chain_ctl_port #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         sdin_i,
  input  logic         sel_i,
  output logic         sdout_o,
  output logic         sel_o,
  output logic [W-1:0] ctrl_o,
  output logic         ctrl_upd_o,
  input  logic [W-1:0] diag_i
);
  localparam int N_EDGE = 2;
  localparam int I_SCK  = 0;
  localparam int I_SEL  = 1;

  logic [N_EDGE-1:0] pins;
  ccp_pkg::edge_t    ev [N_EDGE];
  logic              din_s;
  logic load, shift_in, shift_out, commit;

  assign pins[I_SCK] = sclk_i;
  assign pins[I_SEL] = sel_i;

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    ccp_edge #(.STAGES(STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pins[g]), .ev(ev[g])
    );
  end

  ccp_sync #(.STAGES(STAGES)) u_din (
    .clk(clk), .rst_n(rst_n), .d(sdin_i), .q(din_s)
  );

  ccp_frame_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(ev[I_SEL].level), .sel_rise(ev[I_SEL].rise), .sel_fall(ev[I_SEL].fall),
    .sck_rise(ev[I_SCK].rise), .sck_fall(ev[I_SCK].fall),
    .load(load), .shift_in(shift_in), .shift_out(shift_out), .commit(commit),
    .sel_o(sel_o)
  );

  ccp_shifter #(.W(W)) u_shf (
    .clk(clk), .rst_n(rst_n),
    .load(load), .shift_in(shift_in), .shift_out(shift_out), .commit(commit),
    .din(din_s), .sel_lvl(ev[I_SEL].level), .diag(diag_i),
    .ctrl(ctrl_o), .upd(ctrl_upd_o), .sdout(sdout_o)
  );

  AST_SDOUT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ev[I_SEL].level |-> !sdout_o) else $error("sdout active while deselected"); // R7
  AST_SCK_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev[I_SEL].level |=> !ctrl_upd_o) else $error("update while deselected"); // R7
endmodule

// File: tb/sim_chain_ctl_port.sv
`timescale 1ns/1ps
module sim_chain_ctl_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk, sdin, sel;
  logic [7:0] diag0, diag1;
  logic sdout0, selo0, upd0, sdout1, selo1, upd1;
  logic [7:0] ctrl0, ctrl1;

  chain_ctl_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .sel_i(sel),
    .sdout_o(sdout0), .sel_o(selo0), .ctrl_o(ctrl0), .ctrl_upd_o(upd0), .diag_i(diag0)
  );
  chain_ctl_port u1 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .sel_i(selo0),
    .sdout_o(sdout1), .sel_o(selo1), .ctrl_o(ctrl1), .ctrl_upd_o(upd1), .diag_i(diag1)
  );

  int n_chk = 0, n_fail = 0;
  // reference model state
  bit   stable = 0, open = 0, frozen = 0;
  int   rk = 0, fk = 0, exp_upd0 = 0, cnt_upd0 = 0, cnt_upd1 = 0;
  logic [7:0] rx_m = '0, diag_m = '0, exp_ctrl = '0, got_sd = '0;
  logic exp_sdout = 0, exp_selo = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (upd0) cnt_upd0++;
      if (upd1) cnt_upd1++;
      if (stable) begin
        n_chk++;
        if (ctrl0 !== exp_ctrl || sdout0 !== exp_sdout || selo0 !== exp_selo) begin
          n_fail++;
          $display("FAIL R2/R4/R5/R7 per-clock act ctrl=%h sd=%b so=%b exp ctrl=%h sd=%b so=%b",
                   ctrl0, sdout0, selo0, exp_ctrl, exp_sdout, exp_selo);
        end
      end
    end
  end

  task automatic rise_sck();
    stable = 0; sclk = 1'b1;
    repeat (6) @(negedge clk);
    if (open && !frozen) begin
      rk++;
      if (rk <= 8) begin
        exp_sdout = diag_m[8-rk];
        got_sd[8-rk] = sdout0;
      end
      if (rk == 9 && fk == 8) begin
        exp_ctrl = rx_m;
        exp_upd0++;
      end
    end
    stable = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic fall_sck(input logic d);
    stable = 0; sdin = d;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    if (open && !frozen) begin
      fk++;
      if (fk <= 8) rx_m = {rx_m[6:0], d};
      if (fk == 9) begin frozen = 1; exp_selo = 1; end
    end
    stable = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_sel(input logic v);
    stable = 0; sel = v;
    repeat (6) @(negedge clk);
    if (v) begin
      open = 1; frozen = 0; rk = 0; fk = 0; rx_m = '0; diag_m = diag0;
    end else begin
      open = 0; frozen = 0;
    end
    exp_sdout = 0; exp_selo = 0;
    stable = 1;
    repeat (2) @(negedge clk);
  endtask

  // send npairs clock periods; data bits taken MSB first from word
  task automatic pairs(input logic [7:0] word, input int npairs);
    for (int i = 0; i < npairs; i++) begin
      rise_sck();
      fall_sck(i < 8 ? word[7-i] : 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act timeout exp completion");
    report();
  end

  initial begin
    rst_n = 0; sclk = 0; sdin = 0; sel = 0; diag0 = '0; diag1 = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 ctrl", ctrl0, 0);
    chk("R1 upd", upd0, 0);
    chk("R1 sdout", sdout0, 0);
    chk("R1 sel_o", selo0, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    stable = 1;

    // full frame
    diag0 = 8'h3C;
    set_sel(1);
    chk("R2 sdout before first rise", sdout0, 0);
    pairs(8'hA5, 9);
    chk("R4 ctrl commit", ctrl0, 8'hA5);
    chk("R4 update count", cnt_upd0, 1);
    chk("R2 diag serial order", got_sd, 8'h3C);
    chk("R5 sel_o high after ninth fall", selo0, 1);

    // edges after the hand-off are ignored
    pairs(8'hFF, 3);
    chk("R5 ctrl frozen", ctrl0, 8'hA5);
    chk("R5 no extra update", cnt_upd0, 1);
    chk("R5 sdout held", sdout0, 0);
    set_sel(0);
    chk("R6 sel_o low", selo0, 0);
    chk("R7 sdout low deselected", sdout0, 0);

    // aborted frame: six rises, five falls
    diag0 = 8'hC1;
    set_sel(1);
    pairs(8'h0F, 5);
    rise_sck();
    set_sel(0);
    chk("R6 abort keeps ctrl", ctrl0, 8'hA5);
    chk("R6 abort no update", cnt_upd0, 1);
    fall_sck(1'b1);
    pairs(8'hFF, 2);
    chk("R7 idle edges ctrl", ctrl0, 8'hA5);
    chk("R7 idle edges no update", cnt_upd0, 1);
    chk("R7 idle sdout", sdout0, 0);

    // bit order check with an asymmetric word
    diag0 = 8'h01;
    set_sel(1);
    pairs(8'h1E, 9);
    chk("R3 bit order", ctrl0, 8'h1E);
    chk("R2 diag bit0 last", got_sd, 8'h01);
    chk("R4 second update", cnt_upd0, 2);
    set_sel(0);

    // two ports chained
    diag0 = 8'h96; diag1 = 8'h5A;
    set_sel(1);
    begin
      logic [7:0] w0, w1, g1;
      w0 = 8'h6B; w1 = 8'hD2; g1 = '0;
      for (int i = 1; i <= 18; i++) begin
        rise_sck();
        if (i >= 10 && i <= 17) g1[17-i] = sdout1;
        if (i <= 8)                fall_sck(w0[8-i]);
        else if (i >= 10 && i <= 17) fall_sck(w1[17-i]);
        else                        fall_sck(1'b0);
      end
      chk("R8 first port word", ctrl0, 8'h6B);
      chk("R8 second port word", ctrl1, 8'hD2);
      chk("R8 second port update", cnt_upd1, 1);
      chk("R8 second port diag", g1, 8'h5A);
      chk("R8 second sel_o", selo1, 1);
    end
    set_sel(0);
    chk("R8 chain released", selo1, 0);
    chk("R4 total updates", cnt_upd0, exp_upd0);
    report();
  end
endmodule